// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing core of a host-side controller for an open-drain single-wire data line that has an external pull-up resistor. Each request asks for one bus primitive: an initialization sequence, one write slot carrying a bit, or one read slot. The engine only ever pulls the line low or lets it go. It places every edge and every sample point at a fixed number of microseconds after the primitive starts. It also reports whether a responder answered the initialization and which bit a read slot returned.

The microsecond base is a clock-enable tick. A divider of `CLK_PER_US` system clocks produces it and restarts when a command is accepted, so every event lands an exact whole number of microseconds after acceptance. The line input passes through a two-flop synchronizer before the engine samples it. Byte assembly, device search and device command sets are left to higher layers, which issue one primitive at a time and wait for `done_o`.

Top module: `sw_master_engine`

## Requirements
- R1: After reset, `line_drive_low_o`, `busy_o`, `done_o`, `presence_o` and `rd_bit_o` are all 0.
- R2: A command with `cmd_op_i` = 2'b00 (init) is accepted at a clock edge while idle. From that edge the line is pulled low for exactly `RST_LOW_US` microseconds, and then released.
- R3: During init, `presence_o` is cleared on acceptance. It is then loaded with 1 if the line is low `PRES_US` µs after the release, and with 0 otherwise. It holds that value until the next init command.
- R4: Init ends `RST_HIGH_US` µs after the release. At that edge `busy_o` falls and `done_o` is high for exactly one clock.
- R5: A write command (`cmd_op_i` = 2'b01) with `cmd_wbit_i` = 0 pulls the line low for the full `SLOT_US` µs slot.
- R6: A write command with `cmd_wbit_i` = 1 pulls the line low for `REL_US` µs and then releases it for the rest of the slot.
- R7: A read command (`cmd_op_i` = 2'b10) pulls the line low for `REL_US` µs and then releases it. It samples the line `SMP_US` µs after the slot starts. A high line gives 1 and a low line gives 0. `rd_bit_o` keeps that value until the next read.
- R8: After every slot the line stays released for `REC_US` µs. `busy_o` is high from acceptance to the end of this gap, and then `done_o` pulses for one clock.
- R9: A command presented while `busy_o` is high is ignored. It has no effect on line timing, sampling or outputs.
- R10: `cmd_op_i` = 2'b11 is not a command. It is ignored and the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request, taken only while idle |
| cmd_op_i | input | 2 | 00 init, 01 write, 10 read, 11 none |
| cmd_wbit_i | input | 1 | Bit to write for a write command |
| busy_o | output | 1 | Primitive in progress |
| done_o | output | 1 | One-clock pulse when a primitive ends |
| presence_o | output | 1 | Responder answered the last init |
| rd_bit_o | output | 1 | Bit sampled by the last read slot |
| line_drive_low_o | output | 1 | 1 pulls the line low, 0 releases it |
| line_i | input | 1 | Level of the line |

## Verification
The hardest case to reach is the presence decision. It depends on where a responder's low pulse falls relative to the single sample point. That point is well after the release and far from any edge the engine drives. The bench plays the responder itself: it counts clocks from acceptance and places the pulse either across the sample point or just after it. This checks both outcomes, and also the case of no responder at all. Commands are also injected in the middle of a slot and in the middle of a read. This shows that the primitive already running keeps its timing.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    OP_INIT  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } sw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_SLOT,
    ST_REC
  } sw_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);

  generate
    if (CLK_PER_US > 1) begin : g_gap_chk
      // R2
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] sync_q;

  // idle line level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], d_i};
  end

  assign q_o = sync_q[1];
endmodule

// File: rtl/sw_slot_seq.sv
module sw_slot_seq
  import sw_pkg::*;
#(
  parameter int RST_LOW_US  = 480,
  parameter int PRES_US     = 70,
  parameter int RST_HIGH_US = 480,
  parameter int SLOT_US     = 65,
  parameter int REC_US      = 5,
  parameter int REL_US      = 6,
  parameter int SMP_US      = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_s_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_wbit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       drive_low_o
);
  localparam int MAX_US = max2(max2(RST_LOW_US, RST_HIGH_US), max2(SLOT_US, REC_US));
  localparam int EL_W   = $clog2(MAX_US + 1);

  localparam logic [EL_W-1:0] E_RST_LOW  = EL_W'(RST_LOW_US);
  localparam logic [EL_W-1:0] E_PRES     = EL_W'(PRES_US);
  localparam logic [EL_W-1:0] E_RST_HIGH = EL_W'(RST_HIGH_US);
  localparam logic [EL_W-1:0] E_SLOT     = EL_W'(SLOT_US);
  localparam logic [EL_W-1:0] E_REC      = EL_W'(REC_US);
  localparam logic [EL_W-1:0] E_REL      = EL_W'(REL_US);
  localparam logic [EL_W-1:0] E_SMP      = EL_W'(SMP_US);

  sw_state_e       st_q;
  sw_op_e          op_q;
  sw_op_e          op_in;
  logic            bit_q;
  logic [EL_W-1:0] el_q;
  logic [EL_W-1:0] el_nx;

  assign op_in = sw_op_e'(cmd_op_i);
  assign el_nx = el_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_NONE;
      bit_q       <= 1'b0;
      el_q        <= '0;
      drive_low_o <= 1'b0;
      done_o      <= 1'b0;
      presence_o  <= 1'b0;
      rd_bit_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_valid_i && op_in != OP_NONE) begin
            op_q        <= op_in;
            bit_q       <= cmd_wbit_i;
            el_q        <= '0;
            drive_low_o <= 1'b1;
            if (op_in == OP_INIT) begin
              st_q       <= ST_RST_LOW;
              presence_o <= 1'b0;
            end else begin
              st_q <= ST_SLOT;
            end
          end
        end
        ST_RST_LOW: if (tick_i) begin
          el_q <= el_nx;
          if (el_nx == E_RST_LOW) begin
            drive_low_o <= 1'b0;
            el_q        <= '0;
            st_q        <= ST_RST_WAIT;
          end
        end
        ST_RST_WAIT: if (tick_i) begin
          el_q <= el_nx;
          if (el_nx == E_PRES) presence_o <= !line_s_i;
          if (el_nx == E_RST_HIGH) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        ST_SLOT: if (tick_i) begin
          el_q <= el_nx;
          // write-0 keeps the line low to the slot end
          if (el_nx == E_REL && !(op_q == OP_WRITE && !bit_q)) drive_low_o <= 1'b0;
          if (el_nx == E_SMP && op_q == OP_READ) rd_bit_o <= line_s_i;
          if (el_nx == E_SLOT) begin
            drive_low_o <= 1'b0;
            el_q        <= '0;
            st_q        <= ST_REC;
          end
        end
        ST_REC: if (tick_i) begin
          el_q <= el_nx;
          if (el_nx == E_REC) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> ($stable(op_q) && $stable(bit_q)));
  // R2
  rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RST_LOW) |-> drive_low_o);
  // R5
  w0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOT && op_q == OP_WRITE && !bit_q) |-> drive_low_o);
  // R8
  rec_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REC) |-> !drive_low_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R3
  pres_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOT || st_q == ST_REC) |=> $stable(presence_o));
endmodule

// File: rtl/sw_master_engine.sv
module sw_master_engine #(
  parameter int CLK_PER_US  = 100,
  parameter int RST_LOW_US  = 480,
  parameter int PRES_US     = 70,
  parameter int RST_HIGH_US = 480,
  parameter int SLOT_US     = 65,
  parameter int REC_US      = 5,
  parameter int REL_US      = 6,
  parameter int SMP_US      = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_wbit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       line_drive_low_o,
  input  logic       line_i
);
  logic tick;
  logic line_s;
  logic busy;

  sw_us_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!busy),
    .tick_o (tick)
  );

  sw_line_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (line_s)
  );

  sw_slot_seq #(
    .RST_LOW_US  (RST_LOW_US),
    .PRES_US     (PRES_US),
    .RST_HIGH_US (RST_HIGH_US),
    .SLOT_US     (SLOT_US),
    .REC_US      (REC_US),
    .REL_US      (REL_US),
    .SMP_US      (SMP_US)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .line_s_i    (line_s),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_wbit_i  (cmd_wbit_i),
    .busy_o      (busy),
    .done_o      (done_o),
    .presence_o  (presence_o),
    .rd_bit_o    (rd_bit_o),
    .drive_low_o (line_drive_low_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/test_sw_master_engine.sv
module test_sw_master_engine;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic       cmd_wbit = 1'b0;
  logic       dev_low = 1'b0;
  logic       busy, done, pres, rd, drv;
  logic       line;

  int checks = 0;
  int errors = 0;

  // model state
  bit m_busy = 0, m_done = 0, m_pres = 0, m_rd = 0, m_drv = 0;
  int m_t = 0;
  int m_op = 0;
  bit m_bit = 0;

  always #5 clk = ~clk;

  assign line = !(drv || dev_low);

  sw_master_engine #(.CLK_PER_US(N)) i_sw_master_engine (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cmd_valid_i      (cmd_valid),
    .cmd_op_i         (cmd_op),
    .cmd_wbit_i       (cmd_wbit),
    .busy_o           (busy),
    .done_o           (done),
    .presence_o       (pres),
    .rd_bit_o         (rd),
    .line_drive_low_o (drv),
    .line_i           (line)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, times in clocks since acceptance
  always @(posedge clk) begin
    if (rst_n) begin
      if (!m_busy) begin
        m_done = 0;
        if (cmd_valid && cmd_op != 2'b11) begin
          m_busy = 1; m_t = 0; m_op = cmd_op; m_bit = cmd_wbit; m_drv = 1;
          if (cmd_op == 2'b00) m_pres = 0;
        end
      end else begin
        m_t++;
        if (m_op == 0) begin
          if (m_t == 480 * N) m_drv = 0;
          if (m_t == 550 * N) m_pres = dev_low;
          if (m_t == 960 * N) begin m_busy = 0; m_done = 1; end
        end else begin
          if (m_t == 6 * N && (m_op == 2 || m_bit)) m_drv = 0;
          if (m_t == 15 * N && m_op == 2) m_rd = !dev_low;
          if (m_t == 65 * N) m_drv = 0;
          if (m_t == 70 * N) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy, m_busy, "R8 busy");
      chk(drv,  m_drv,  "R2 R5 R6 drive");
      chk(done, m_done, "R4 done");
      chk(pres, m_pres, "R3 presence");
      chk(rd,   m_rd,   "R7 rd_bit");
    end
  end

  task automatic issue(input logic [1:0] op, input logic b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(drv, 1'b0, "R1 drive"); chk(busy, 1'b0, "R1 busy"); chk(done, 1'b0, "R1 done");
    chk(pres, 1'b0, "R1 presence"); chk(rd, 1'b0, "R1 rd_bit");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: op 11 ignored
    issue(2'b11, 1'b1);
    repeat (5) @(negedge clk);
    chk(busy, 1'b0, "R10 busy"); chk(drv, 1'b0, "R10 drive");

    // R3: responder pulse across sample point
    issue(2'b00, 1'b0);
    repeat (510 * N) @(negedge clk);
    dev_low = 1'b1;
    repeat (100 * N) @(negedge clk);
    dev_low = 1'b0;
    wait_idle();
    chk(pres, 1'b1, "R3 present");

    // R3: no responder
    issue(2'b00, 1'b0);
    wait_idle();
    chk(pres, 1'b0, "R3 absent");

    // R3: pulse starts after the sample point
    issue(2'b00, 1'b0);
    repeat (560 * N) @(negedge clk);
    dev_low = 1'b1;
    repeat (60 * N) @(negedge clk);
    dev_low = 1'b0;
    wait_idle();
    chk(pres, 1'b0, "R3 late pulse");

    // R5, R6
    issue(2'b01, 1'b0); wait_idle();
    issue(2'b01, 1'b1); wait_idle();

    // R7: read high then low
    issue(2'b10, 1'b0); wait_idle();
    chk(rd, 1'b1, "R7 read 1");
    dev_low = 1'b1;
    issue(2'b10, 1'b0); wait_idle();
    dev_low = 1'b0;
    chk(rd, 1'b0, "R7 read 0");

    // R9: commands while busy
    issue(2'b01, 1'b0);
    repeat (20 * N) @(negedge clk);
    issue(2'b10, 1'b0);
    wait_idle();
    chk(rd, 1'b0, "R9 read ignored");
    issue(2'b10, 1'b0);
    repeat (10 * N) @(negedge clk);
    issue(2'b00, 1'b0);
    wait_idle();
    chk(rd, 1'b1, "R9 read result");
    chk(pres, 1'b0, "R9 presence untouched");

    // R8: command held across done, back-to-back slots
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_wbit = 1'b1;
    repeat (150 * N) @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule